// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

A bank of independent 32-bit down-counting timer channels behind a simple synchronous register port. Each channel has a control word, an initial-count value and a readable live count. A per-channel prescaler turns the block clock into a slower tick, and the counter loses one on each tick. When the count runs out, the channel either reloads and carries on (periodic) or stops (one-shot). In both cases it sets its bit in a shared pending register, which drives an interrupt line when that channel's interrupt enable is set. Software clears pending bits by writing ones to them.

Each channel is a two-state machine. In `CH_HOLD` the count is frozen. In `CH_RUN` it counts. The transitions are: *start* (control write with enable set, HOLD→RUN), *stop* (control write with enable clear, RUN→HOLD), *one-shot expiry* (RUN→HOLD) and *periodic expiry* (RUN→RUN with a reload). If a control write and an expiry fall in the same cycle, the written enable decides the next state. Disabling a channel pauses it. Re-enabling it resumes from the frozen count. A change of prescaler re-times the remaining count from the value it holds at that moment.

Register addresses are word indices on `reg_addr`. When the top address bit is set, the pending register is selected. Otherwise the bits above the two low bits select the channel, and the two low bits select a slot: 0 control, 1 initial count, 2 live count (read-only), 3 reads zero. With the default of two channels, channel c sits at 4c..4c+3 and the pending register sits at 8.

Top module: `interval_timer`

## Requirements
- R1: After reset every control word reads 0x00000005 (prescale 5, stopped, one-shot, interrupt disabled). Initial count, live count and the pending register all read zero, and every `irq` bit is low.
- R2: Let P be control bits [7:0], and let E be the clock edge that starts a channel. While the channel runs, its count drops by exactly one at edges E+k·(P+1), k = 1, 2, …, and at no other edge.
- R3: Writing control with bit 30 clear freezes the count. No tick is taken at that write edge, and the count stays fixed while the channel is stopped. A later start resumes from the frozen value and restarts the prescaler.
- R4: Control bit 30 (enable) and bit 25 (active) always read back equal: 1 while running and 0 while stopped. Bit 25 ignores writes.
- R5: When the mode field, control bits [28:27], is 01 (periodic), a tick that finds the count at 1 or below reloads it from the initial count, and the channel keeps running.
- R6: When the mode field holds any other value (one-shot), such a tick sets the count to 0 and stops the channel, which clears bits 30 and 25.
- R7: Every expiry (a tick that finds the count at 1 or below) sets bit c of the pending register for channel c at that same edge. An expiry takes priority over a clear written in the same cycle.
- R8: `irq[c]` equals pending bit c AND control bit 29 of channel c, with no register in between.
- R9: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: Writing a new prescale value while running restarts the prescaler and takes no tick at that edge. The count then falls once per new P+1 edges, starting from the value it held.
- R11: Writing the initial count loads it into the live count at that edge and restarts the prescaler. The run/stop state does not change: a running channel goes on counting from the new value, and a stopped one stays frozen at it.
- R12: When `reg_rd` is high at an edge, `reg_rdata` presents the addressed register's value from before that edge, and holds it until the next read. Slot 3 reads zero. The mode and prescale fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W (4) | Word address: pending select, channel, slot |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | NUM_CH (2) | Per-channel interrupt request |

## Verification
Properties check, on every cycle, that the count changes only on a tick or an initial-count write, and that a running count steps down by exactly one per tick. They also check that a stopped channel holds its count, that one-shot and periodic expiries land in the right state and count, and that pending bits obey set-over-clear and write-one-to-clear. Only the bench scenarios can show the absolute timing of ticks from a start edge, the resume value after a pause, the rescale after a prescaler change and the register decode. These scenarios compare read-back counts, control words, pending bits and `irq` against values computed from the elapsed clock edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control word field positions
    localparam int CTRL_PSC_LO  = 0;
    localparam int CTRL_ACT     = 25;
    localparam int CTRL_MODE_LO = 27;
    localparam int CTRL_IE      = 29;
    localparam int CTRL_EN      = 30;

    localparam logic [1:0]  MODE_PERIODIC = 2'b01;
    localparam logic [31:0] CTRL_RST      = 32'h0000_0005;

    typedef enum logic [1:0] {
        SLOT_CTRL  = 2'd0,
        SLOT_INIT  = 2'd1,
        SLOT_COUNT = 2'd2,
        SLOT_RSVD  = 2'd3
    } slot_e;

    typedef enum logic {
        CH_HOLD = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || restart) begin
            div_q <= '0;
        end else if (div_q >= psc) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && !restart && (div_q >= psc);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             init_wr,
    input  logic             wr_en,
    input  logic             wr_ie,
    input  logic [1:0]       wr_mode,
    input  logic [PSC_W-1:0] wr_psc,
    input  logic [CNT_W-1:0] wr_init,
    output logic [31:0]      ctrl_word,
    output logic [CNT_W-1:0] init_q,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_en,
    output logic             expire
);

    ch_state_e        state_q, state_d;
    logic [PSC_W-1:0] psc_q;
    logic [1:0]       mode_q;
    logic             ie_q;
    logic             running, periodic;
    logic             psc_change, stop_now, restart;
    logic             tick, do_tick;

    assign running    = (state_q == CH_RUN);
    assign periodic   = (mode_q == MODE_PERIODIC);
    assign psc_change = ctrl_wr && (wr_psc != psc_q);
    assign stop_now   = ctrl_wr && !wr_en;
    assign restart    = psc_change || init_wr;

    tmr_prescaler #(.PSC_W(PSC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (restart),
        .psc     (psc_q),
        .tick    (tick)
    );

    assign do_tick = tick && !stop_now;
    assign expire  = do_tick && (count_q <= CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, stop, one-shot expiry, periodic expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HOLD: begin
                if (ctrl_wr && wr_en) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (ctrl_wr) begin
                    state_d = wr_en ? CH_RUN : CH_HOLD;
                end else if (expire && !periodic) begin
                    state_d = CH_HOLD;
                end
            end
            default: state_d = CH_HOLD;
        endcase
    end

    // Configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= CTRL_RST[PSC_W-1:0];
            mode_q <= CTRL_RST[CTRL_MODE_LO +: 2];
            ie_q   <= CTRL_RST[CTRL_IE];
        end else if (ctrl_wr) begin
            psc_q  <= wr_psc;
            mode_q <= wr_mode;
            ie_q   <= wr_ie;
        end
    end

    // Initial count and live count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q  <= '0;
            count_q <= '0;
        end else if (init_wr) begin
            init_q  <= wr_init;
            count_q <= wr_init;
        end else if (expire) begin
            count_q <= periodic ? init_q : '0;
        end else if (do_tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CTRL_PSC_LO +: PSC_W]  = psc_q;
        ctrl_word[CTRL_MODE_LO +: 2]     = mode_q;
        ctrl_word[CTRL_IE]               = ie_q;
        ctrl_word[CTRL_EN]               = running;
        ctrl_word[CTRL_ACT]              = running;
    end

    assign irq_en = ie_q;

    // Stopped channel holds its count (R3)
    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HOLD && !init_wr) |=> $stable(count_q));

    // Count only moves on a tick (R2)
    p_idle_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_tick && !init_wr) |=> $stable(count_q));

    // A non-expiring tick takes exactly one off (R2)
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_tick && !expire && !init_wr) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // One-shot expiry stops at zero (R6)
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic && !ctrl_wr && !init_wr) |=> (state_q == CH_HOLD && count_q == '0));

    // Periodic expiry reloads and keeps running (R5)
    p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic && !ctrl_wr && !init_wr) |=> (state_q == CH_RUN && count_q == init_q));

endmodule

// File: rtl/tmr_pending.sv
module tmr_pending #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] pend_q
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (set[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    // Expiry sets its bit, even against a clear (R7)
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((pend_q & $past(set)) == $past(set)));

    // Write-one clears (R9)
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((pend_q & $past(clr & ~set)) == '0));

    // No set and no clear leaves the register alone (R9)
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set == '0 && clr == '0) |=> $stable(pend_q));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter  int NUM_CH = 2,
    parameter  int CNT_W  = 32,
    parameter  int PSC_W  = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic            is_pend;
    logic [CH_W-1:0] ch_sel;
    slot_e           slot;

    assign is_pend = reg_addr[ADDR_W-1];
    assign ch_sel  = reg_addr[CH_W+1:2];
    assign slot    = slot_e'(reg_addr[1:0]);

    logic [31:0]       ctrl_v  [NUM_CH];
    logic [CNT_W-1:0]  init_v  [NUM_CH];
    logic [CNT_W-1:0]  count_v [NUM_CH];
    logic [NUM_CH-1:0] ie_v;
    logic [NUM_CH-1:0] exp_v;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] pend_clr;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = !is_pend && (ch_sel == CH_W'(g));

        tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr   (reg_wr && hit && (slot == SLOT_CTRL)),
            .init_wr   (reg_wr && hit && (slot == SLOT_INIT)),
            .wr_en     (reg_wdata[CTRL_EN]),
            .wr_ie     (reg_wdata[CTRL_IE]),
            .wr_mode   (reg_wdata[CTRL_MODE_LO +: 2]),
            .wr_psc    (reg_wdata[CTRL_PSC_LO +: PSC_W]),
            .wr_init   (reg_wdata[CNT_W-1:0]),
            .ctrl_word (ctrl_v[g]),
            .init_q    (init_v[g]),
            .count_q   (count_v[g]),
            .irq_en    (ie_v[g]),
            .expire    (exp_v[g])
        );

        assign irq[g] = pend_q[g] & ie_v[g];
    end

    assign pend_clr = (reg_wr && is_pend) ? reg_wdata[NUM_CH-1:0] : '0;

    tmr_pending #(.NUM_CH(NUM_CH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (exp_v),
        .clr    (pend_clr),
        .pend_q (pend_q)
    );

    logic [31:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (is_pend) begin
            rd_word[NUM_CH-1:0] = pend_q;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel == CH_W'(i)) begin
                    unique case (slot)
                        SLOT_CTRL:  rd_word = ctrl_v[i];
                        SLOT_INIT:  rd_word = 32'(init_v[i]);
                        SLOT_COUNT: rd_word = 32'(count_v[i]);
                        default:    rd_word = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_word;
        end
    end

endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;

    localparam int CLK_P  = 10;
    localparam int A_PEND = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    interval_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, output int ce);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        ce = cyc;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output int cs);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        cs = cyc - 1;
    endtask

    function automatic logic [31:0] mk_ctrl(bit en, bit ie, logic [1:0] mode, logic [7:0] psc);
        logic [31:0] w = '0;
        w[7:0]   = psc;
        w[28:27] = mode;
        w[29]    = ie;
        w[30]    = en;
        w[25]    = en;
        return w;
    endfunction

    function automatic logic [31:0] m_count(int init, int m, bit per);
        if (per) begin
            int r = m % init;
            return (r == 0) ? 32'(init) : 32'(init - r);
        end
        return (m >= init) ? 32'd0 : 32'(init - m);
    endfunction

    function automatic int a_ctrl(int c);  return c * 4;     endfunction
    function automatic int a_init(int c);  return c * 4 + 1; endfunction
    function automatic int a_cnt(int c);   return c * 4 + 2; endfunction

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements) act=timeout exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, v1, v2;
        int t, ce, cd, ce2, cw, ci, cs;

        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        for (int c = 0; c < 2; c++) begin
            rd(a_ctrl(c), d, t); chk("R1 ctrl reset", d, 32'h0000_0005);
            rd(a_init(c), d, t); chk("R1 init reset", d, 32'h0);
            rd(a_cnt(c), d, t);  chk("R1 count reset", d, 32'h0);
            rd(c * 4 + 3, d, t); chk("R12 slot3 zero", d, 32'h0);
        end
        rd(A_PEND, d, t); chk("R1 pending reset", d, 32'h0);
        chk("R1 irq reset", 32'(irq), 32'h0);

        // One-shot expiry, pending, irq and write-one-to-clear
        wr(a_init(0), 32'd2, t);
        wr(a_ctrl(0), mk_ctrl(1, 1, 2'b00, 8'd0), ce);
        repeat (6) @(negedge clk);
        rd(A_PEND, d, t);    chk("R7 pending set", d & 32'h1, 32'h1);
        rd(a_cnt(0), d, t);  chk("R6 one-shot count zero", d, 32'h0);
        rd(a_ctrl(0), d, t); chk("R6 one-shot stopped", d, mk_ctrl(0, 1, 2'b00, 8'd0));
        chk("R8 irq high", 32'(irq[0]), 32'h1);
        wr(A_PEND, 32'h0, t);
        rd(A_PEND, d, t);    chk("R9 write zero keeps", d & 32'h1, 32'h1);
        wr(a_ctrl(0), mk_ctrl(0, 0, 2'b00, 8'd0), t);
        chk("R8 irq masked", 32'(irq[0]), 32'h0);
        rd(A_PEND, d, t);    chk("R8 pending kept when masked", d & 32'h1, 32'h1);
        wr(A_PEND, 32'h1, t);
        rd(A_PEND, d, t);    chk("R9 write one clears", d & 32'h1, 32'h0);

        // Pause and resume
        wr(a_ctrl(1), mk_ctrl(0, 0, 2'b01, 8'd3), t);
        wr(a_init(1), 32'd100, t);
        wr(a_ctrl(1), mk_ctrl(1, 0, 2'b01, 8'd3), ce);
        rd(a_ctrl(1), d, t); chk("R4 enable and active set", d, mk_ctrl(1, 0, 2'b01, 8'd3));
        repeat (20) @(negedge clk);
        wr(a_ctrl(1), mk_ctrl(0, 0, 2'b01, 8'd3), cd);
        v1 = 32'(100 - (cd - 1 - ce) / 4);
        rd(a_cnt(1), d, t);  chk("R3 frozen value", d, v1);
        repeat (30) @(negedge clk);
        rd(a_cnt(1), d, t);  chk("R3 stays frozen", d, v1);
        rd(a_ctrl(1), d, t); chk("R4 enable and active clear", d, mk_ctrl(0, 0, 2'b01, 8'd3));
        wr(a_ctrl(1), mk_ctrl(1, 0, 2'b01, 8'd3), ce2);
        repeat (17) @(negedge clk);
        rd(a_cnt(1), d, cs); chk("R3 resume from frozen", d, v1 - 32'((cs - ce2) / 4));

        // Prescaler change while running
        wr(a_ctrl(1), mk_ctrl(1, 0, 2'b01, 8'd1), cw);
        v2 = v1 - 32'((cw - 1 - ce2) / 4);
        repeat (13) @(negedge clk);
        rd(a_cnt(1), d, cs); chk("R10 rescaled count", d, v2 - 32'((cs - cw) / 2));

        // Initial-count rewrite while running and while stopped
        wr(a_init(1), 32'd50, ci);
        repeat (9) @(negedge clk);
        rd(a_ctrl(1), d, t); chk("R11 keeps running", d, mk_ctrl(1, 0, 2'b01, 8'd1));
        rd(a_cnt(1), d, cs); chk("R11 reload while running", d, 32'(50 - (cs - ci) / 2));
        wr(a_ctrl(1), mk_ctrl(0, 0, 2'b01, 8'd1), t);
        wr(a_init(1), 32'd7, t);
        rd(a_cnt(1), d, t);  chk("R11 reload while stopped", d, 32'd7);
        repeat (10) @(negedge clk);
        rd(a_cnt(1), d, t);  chk("R3 stopped after reload", d, 32'd7);
        rd(a_ctrl(1), d, t); chk("R11 stays stopped", d, mk_ctrl(0, 0, 2'b01, 8'd1));

        // Constrained random runs
        for (int it = 0; it < 40; it++) begin
            int c    = int'($urandom % 2);
            int p    = int'($urandom % 6);
            int init = 1 + int'($urandom % 12);
            bit per  = bit'($urandom % 2);
            bit ie   = bit'($urandom % 2);
            logic [1:0] mode;
            int m;
            bit run;
            if (per) mode = 2'b01;
            else begin
                case ($urandom % 3)
                    0: mode = 2'b00;
                    1: mode = 2'b10;
                    default: mode = 2'b11;
                endcase
            end
            wr(a_ctrl(c), mk_ctrl(0, ie, mode, 8'(p)), t);
            wr(a_init(c), 32'(init), t);
            wr(A_PEND, 32'(1 << c), t);
            wr(a_ctrl(c), mk_ctrl(1, ie, mode, 8'(p)), ce);
            repeat (int'($urandom % 70)) @(negedge clk);
            rd(a_cnt(c), d, cs);
            m = (cs - ce) / (p + 1);
            chk(per ? "R2 R5 periodic count" : "R2 R6 one-shot count", d, m_count(init, m, per));
            m = (cyc - ce) / (p + 1);
            chk("R8 irq follows pending", 32'(irq[c]), 32'(ie && (m >= init)));
            rd(A_PEND, d, cs);
            m = (cs - ce) / (p + 1);
            chk("R7 pending after run", 32'(d[c]), 32'(m >= init));
            rd(a_ctrl(c), d, cs);
            m = (cs - ce) / (p + 1);
            run = per || (m < init);
            chk("R4 R12 control readback", d, mk_ctrl(run, ie, mode, 8'(p)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule